// File: doc/BRIEF.md
# Clock Rate Configuration Stage with Trigger Commit

This block turns one of several parent clock-enable streams into a single enable pulse stream at a programmed lower rate. A parent selector picks the source. An integer pre-divider thins the selected stream. A downstream divider with fractional bits then spreads the remaining pulses evenly, using a phase accumulator. All three settings sit in staged registers that a simple write port fills. They reach the datapath only when software sets a commit bit. That bit stays high for a fixed busy time, and the new setting applies as it clears.

Two commit bits exist. The early one moves the selector and the pre-divider. The late one moves the downstream divider. Commits are refused while the stage's clock enable is low. The selector leaves reset on a code that has no parent behind it, so the output stays silent until a real source is committed.

Top module: `clk_rate_stage`

## Requirements
- R1: After reset the active selector code is 3, the active pre-divider field is 0, the active downstream field is 8'h08 (divisor 2.0), both busy outputs are 0 and tick_o is 0.
- R2: A write to address 3 with bit 1 set while clk_en_i is high raises pre_busy_o for exactly 8 cycles. When it falls, act_sel_o and act_pre_o take the staged values held at address 2 (selector) and address 1 (pre-divider field).
- R3: A write to address 3 with bit 0 set while clk_en_i is high raises main_busy_o for exactly 8 cycles. When it falls, act_div_o takes the staged value from address 0. The selector and pre-divider do not change.
- R4: A commit write made while clk_en_i is low is ignored. The busy output stays 0 and the active fields do not change.
- R5: A commit write to a trigger that is already busy is ignored and does not restart its busy time.
- R6: While the active selector code is 3 (no parent mapped to it), tick_o stays 0.
- R7: The downstream field holds divisor minus one, with 3 fractional bits. The divisor is field/8 + 1, so field 8'h0C gives 2.5 and produces 2 pulses per 5 input pulses.
- R8: The pre-divider field holds divisor minus one, with no fraction. Field 2 passes one in every 3 selected parent pulses.
- R9: Only parent_tick_i[act_sel_o] feeds the divider chain. Codes 0, 1 and 2 select parents 0, 1 and 2.
- R10: tick_o is registered one cycle after the parent pulse that causes it. Parent pulses that arrive while clk_en_i is low are ignored.
- R11: The cycle in which either commit completes clears the pre-divider count and the phase accumulator, and tick_o is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_en_i | input | 1 | Stage enable; gates the inputs and commits |
| parent_tick_i | input | 3 | Enable pulses from the three parent sources |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | 0 div staged, 1 pre staged, 2 sel staged, 3 commit |
| wr_data_i | input | 8 | Write data |
| pre_busy_o | output | 1 | Selector/pre-divider commit in progress |
| main_busy_o | output | 1 | Downstream divider commit in progress |
| act_sel_o | output | 2 | Active selector code |
| act_pre_o | output | 4 | Active pre-divider field |
| act_div_o | output | 8 | Active downstream divider field |
| tick_o | output | 1 | Divided enable pulse |

## Verification
The assertions check the following on every cycle:
- the exact busy length of each trigger;
- that the active fields stay stable except on a commit edge;
- that commits are refused while disabled;
- that no pulse follows an unmapped selector or a disabled cycle.

The pulse ratios need a modelled scenario: fractional spreading, the pre-divider count, the choice of parent, and the clearing on commit. For these the bench keeps a behavioural model that it compares every clock, and it adds windowed pulse counts for fixed settings.

// File: rtl/clk_rate_pkg.sv
package clk_rate_pkg;
  parameter int DIV_W     = 8;
  parameter int FRAC_W    = 3;
  parameter int PRE_W     = 4;
  parameter int SEL_W     = 2;
  parameter int N_PARENTS = 3;
  parameter int BUSY_CYC  = 8;
  parameter int ADDR_W    = 2;
  parameter int DATA_W    = 8;

  localparam logic [SEL_W-1:0] SEL_RST = SEL_W'(3);
  localparam logic [PRE_W-1:0] PRE_RST = '0;
  localparam logic [DIV_W-1:0] DIV_RST = DIV_W'(8);

  typedef enum logic [ADDR_W-1:0] {
    A_DIV  = 2'd0,
    A_PRE  = 2'd1,
    A_SEL  = 2'd2,
    A_TRIG = 2'd3
  } reg_addr_e;

  // commit bit positions in the trigger word
  localparam int T_MAIN = 0;
  localparam int T_PRE  = 1;
endpackage

// File: rtl/cdiv_trig.sv
module cdiv_trig #(
  parameter int BUSY_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CNT_W = (BUSY_CYC > 1) ? $clog2(BUSY_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BUSY_CYC - 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  assign done_o = busy_q && (cnt_q == LAST);
  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (done_o) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end
  end
endmodule

// File: rtl/cdiv_pre.sv
module cdiv_pre #(
  parameter int PRE_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             in_tick_i,
  input  logic [PRE_W-1:0] field_i,
  output logic             out_tick_o
);
  logic [PRE_W-1:0] cnt_q;
  logic             wrap;

  assign wrap       = (cnt_q == field_i);
  assign out_tick_o = in_tick_i && wrap && !clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (clr_i)     cnt_q <= '0;
    else if (in_tick_i) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/cdiv_frac.sv
module cdiv_frac #(
  parameter int DIV_W  = 8,
  parameter int FRAC_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             in_tick_i,
  input  logic [DIV_W-1:0] field_i,
  output logic             tick_o
);
  localparam int ACC_W = DIV_W + 2;
  localparam logic [ACC_W-1:0] STEP = ACC_W'(1) << FRAC_W;

  logic [ACC_W-1:0] acc_q, acc_nxt, scaled;
  logic             tick_q, hit;

  // implied +1 sits just above the fraction
  assign scaled  = ACC_W'(field_i) + STEP;
  assign acc_nxt = acc_q + STEP;
  assign hit     = (acc_nxt >= scaled);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else if (clr_i) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else if (in_tick_i) begin
      acc_q  <= hit ? acc_nxt - scaled : acc_nxt;
      tick_q <= hit;
    end else begin
      tick_q <= 1'b0;
    end
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/clk_rate_stage.sv
module clk_rate_stage
  import clk_rate_pkg::*;
#(
  parameter int P_DIV_W     = DIV_W,
  parameter int P_FRAC_W    = FRAC_W,
  parameter int P_PRE_W     = PRE_W,
  parameter int P_SEL_W     = SEL_W,
  parameter int P_N_PARENTS = N_PARENTS,
  parameter int P_BUSY_CYC  = BUSY_CYC
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clk_en_i,
  input  logic [P_N_PARENTS-1:0] parent_tick_i,
  input  logic                   wr_en_i,
  input  logic [ADDR_W-1:0]      wr_addr_i,
  input  logic [DATA_W-1:0]      wr_data_i,
  output logic                   pre_busy_o,
  output logic                   main_busy_o,
  output logic [P_SEL_W-1:0]     act_sel_o,
  output logic [P_PRE_W-1:0]     act_pre_o,
  output logic [P_DIV_W-1:0]     act_div_o,
  output logic                   tick_o
);
  localparam int N_TRIG = 2;

  logic [P_DIV_W-1:0] st_div_q, act_div_q;
  logic [P_PRE_W-1:0] st_pre_q, act_pre_q;
  logic [P_SEL_W-1:0] st_sel_q, act_sel_q;
  logic [N_TRIG-1:0]  trig_start, trig_busy, trig_done;
  logic               trig_wr, commit_clr, par_tick, in_tick, pre_tick;

  // staged fields
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_div_q <= DIV_RST;
      st_pre_q <= PRE_RST;
      st_sel_q <= SEL_RST;
    end else if (wr_en_i) begin
      case (reg_addr_e'(wr_addr_i))
        A_DIV:   st_div_q <= wr_data_i[P_DIV_W-1:0];
        A_PRE:   st_pre_q <= wr_data_i[P_PRE_W-1:0];
        A_SEL:   st_sel_q <= wr_data_i[P_SEL_W-1:0];
        default: ;
      endcase
    end
  end

  assign trig_wr = wr_en_i && (reg_addr_e'(wr_addr_i) == A_TRIG) && clk_en_i;

  generate
    for (genvar g = 0; g < N_TRIG; g++) begin : g_trig
      assign trig_start[g] = trig_wr && wr_data_i[g];
      cdiv_trig #(.BUSY_CYC(P_BUSY_CYC)) u_trig (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .start_i(trig_start[g]),
        .busy_o (trig_busy[g]),
        .done_o (trig_done[g])
      );
    end
  endgenerate

  // active fields move on trigger completion
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_sel_q <= SEL_RST;
      act_pre_q <= PRE_RST;
      act_div_q <= DIV_RST;
    end else begin
      if (trig_done[T_PRE]) begin
        act_sel_q <= st_sel_q;
        act_pre_q <= st_pre_q;
      end
      if (trig_done[T_MAIN]) act_div_q <= st_div_q;
    end
  end

  assign commit_clr = |trig_done;

  // unmapped codes select nothing
  always_comb begin
    par_tick = 1'b0;
    for (int i = 0; i < P_N_PARENTS; i++)
      if (act_sel_q == P_SEL_W'(i)) par_tick = parent_tick_i[i];
  end

  assign in_tick = clk_en_i && par_tick;

  cdiv_pre #(.PRE_W(P_PRE_W)) u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (commit_clr),
    .in_tick_i (in_tick),
    .field_i   (act_pre_q),
    .out_tick_o(pre_tick)
  );

  cdiv_frac #(.DIV_W(P_DIV_W), .FRAC_W(P_FRAC_W)) u_frac (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (commit_clr),
    .in_tick_i(pre_tick),
    .field_i  (act_div_q),
    .tick_o   (tick_o)
  );

  assign pre_busy_o  = trig_busy[T_PRE];
  assign main_busy_o = trig_busy[T_MAIN];
  assign act_sel_o   = act_sel_q;
  assign act_pre_o   = act_pre_q;
  assign act_div_o   = act_div_q;
endmodule

// File: rtl/clk_rate_stage_chk.sv
module clk_rate_stage_chk
  import clk_rate_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clk_en_i,
  input logic             trig_wr_i,
  input logic             pre_bit_i,
  input logic             main_bit_i,
  input logic             pre_busy_o,
  input logic             main_busy_o,
  input logic [SEL_W-1:0] act_sel_o,
  input logic [PRE_W-1:0] act_pre_o,
  input logic [DIV_W-1:0] act_div_o,
  input logic             tick_o
);
  logic [15:0] run_p, run_m;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_p <= '0;
      run_m <= '0;
    end else begin
      run_p <= pre_busy_o  ? run_p + 1'b1 : '0;
      run_m <= main_busy_o ? run_m + 1'b1 : '0;
    end
  end

  p_pre_len_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pre_busy_o) |-> run_p == 16'(BUSY_CYC));
  p_pre_max_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_busy_o |-> run_p < 16'(BUSY_CYC));
  p_main_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(main_busy_o) |-> run_m == 16'(BUSY_CYC));
  p_main_max_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    main_busy_o |-> run_m < 16'(BUSY_CYC));
  p_sel_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(pre_busy_o) |-> ($stable(act_sel_o) && $stable(act_pre_o)));
  p_div_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(main_busy_o) |-> $stable(act_div_o));
  p_off_pre_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_wr_i && pre_bit_i && !clk_en_i && !pre_busy_o) |=> !pre_busy_o);
  p_off_main_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_wr_i && main_bit_i && !clk_en_i && !main_busy_o) |=> !main_busy_o);
  p_no_map_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> ($past(act_sel_o) < SEL_W'(N_PARENTS)));
  p_gated_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> $past(clk_en_i));
endmodule

bind clk_rate_stage clk_rate_stage_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .clk_en_i   (clk_en_i),
  .trig_wr_i  (wr_en_i && (wr_addr_i == 2'd3)),
  .pre_bit_i  (wr_data_i[1]),
  .main_bit_i (wr_data_i[0]),
  .pre_busy_o (pre_busy_o),
  .main_busy_o(main_busy_o),
  .act_sel_o  (act_sel_o),
  .act_pre_o  (act_pre_o),
  .act_div_o  (act_div_o),
  .tick_o     (tick_o)
);

// File: tb/clk_rate_stage_test.sv
`timescale 1ns/1ps
module clk_rate_stage_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clk_en = 1'b1;
  logic [2:0] ptick = 3'b000;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       pre_busy, main_busy, tick;
  logic [1:0] act_sel;
  logic [3:0] act_pre;
  logic [7:0] act_div;

  int tests = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  clk_rate_stage uut (
    .clk_i(clk), .rst_ni(rst_n), .clk_en_i(clk_en), .parent_tick_i(ptick),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .pre_busy_o(pre_busy), .main_busy_o(main_busy), .act_sel_o(act_sel),
    .act_pre_o(act_pre), .act_div_o(act_div), .tick_o(tick)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // parent 0 every cycle, parent 1 every 2nd, parent 2 every 3rd
  always @(negedge clk) begin
    cyc++;
    ptick <= {cyc % 3 == 0, cyc % 2 == 0, 1'b1};
  end

  // behavioural reference model
  int m_sel = 3, m_pre = 0, m_div = 8, s_sel = 3, s_pre = 0, s_div = 8;
  int m_pb = 0, m_pc = 0, m_mb = 0, m_mc = 0, m_acc = 0, m_pcnt = 0, m_tick = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sel = 3; m_pre = 0; m_div = 8; s_sel = 3; s_pre = 0; s_div = 8;
      m_pb = 0; m_pc = 0; m_mb = 0; m_mc = 0; m_acc = 0; m_pcnt = 0; m_tick = 0;
    end else begin
      int t, pd, md;
      bit tw;
      t = 0;
      if (clk_en && m_sel < 3 && ptick[m_sel]) begin
        if (m_pcnt == m_pre) begin
          m_pcnt = 0;
          m_acc += 8;
          if (m_acc >= m_div + 8) begin t = 1; m_acc -= m_div + 8; end
        end else m_pcnt++;
      end
      pd = (m_pb == 1 && m_pc == 7) ? 1 : 0;
      md = (m_mb == 1 && m_mc == 7) ? 1 : 0;
      tw = wr_en && wr_addr == 2'd3 && clk_en;
      if (m_pb == 1) begin if (pd == 1) m_pb = 0; else m_pc++; end
      else if (tw && wr_data[1]) begin m_pb = 1; m_pc = 0; end
      if (m_mb == 1) begin if (md == 1) m_mb = 0; else m_mc++; end
      else if (tw && wr_data[0]) begin m_mb = 1; m_mc = 0; end
      if (pd == 1) begin m_sel = s_sel; m_pre = s_pre; end
      if (md == 1) m_div = s_div;
      if (pd == 1 || md == 1) begin m_acc = 0; m_pcnt = 0; t = 0; end
      m_tick = t;
      if (wr_en) case (wr_addr)
        2'd0: s_div = int'(wr_data);
        2'd1: s_pre = int'(wr_data[3:0]);
        2'd2: s_sel = int'(wr_data[1:0]);
        default: ;
      endcase
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) if (rst_n && !done) begin
    chk("R10/R11 tick", int'(tick), m_tick);
    chk("R2 pre busy", int'(pre_busy), m_pb);
    chk("R3 main busy", int'(main_busy), m_mb);
    chk("R2 act sel", int'(act_sel), m_sel);
    chk("R2 act pre", int'(act_pre), m_pre);
    chk("R3 act div", int'(act_div), m_div);
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic count(input int n, output int c);
    c = 0;
    repeat (n) begin @(negedge clk); c += int'(tick); end
  endtask

  task automatic settle();
    repeat (10) @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    fails++; tests++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int c, n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 sel", int'(act_sel), 3);
    chk("R1 pre", int'(act_pre), 0);
    chk("R1 div", int'(act_div), 8);
    chk("R1 busy", int'(pre_busy | main_busy), 0);
    chk("R1 tick", int'(tick), 0);

    // R6 unmapped code, enabled, parents toggling
    count(20, c);
    chk("R6 no ticks", c, 0);

    // R4 commit while disabled
    wr(2'd2, 8'd1);
    clk_en = 1'b0;
    wr(2'd3, 8'h03);
    chk("R4 pre busy", int'(pre_busy), 0);
    chk("R4 main busy", int'(main_busy), 0);
    settle();
    chk("R4 sel kept", int'(act_sel), 3);
    clk_en = 1'b1;

    // R2 + R5: commit, retrigger while busy
    wr(2'd3, 8'h02);
    n = 0;
    while (pre_busy && n < 50) begin
      n++;
      if (n == 3) begin wr_en = 1'b1; wr_addr = 2'd3; wr_data = 8'h02; end
      else wr_en = 1'b0;
      @(negedge clk);
    end
    wr_en = 1'b0;
    chk("R5 busy length", n, 8);
    chk("R2 sel applied", int'(act_sel), 1);
    settle();
    chk("R5 no restart", int'(pre_busy), 0);

    // R9 parent 2, divisor 1
    wr(2'd0, 8'd0);
    wr(2'd3, 8'h01);
    settle();
    chk("R3 div applied", int'(act_div), 0);
    chk("R3 sel kept", int'(act_sel), 1);
    wr(2'd2, 8'd2);
    wr(2'd3, 8'h02);
    settle();
    count(30, c);
    chk("R9 parent2 rate", c, 10);

    // R7 fractional 2.5 on parent 0
    wr(2'd0, 8'h0C);
    wr(2'd2, 8'd0);
    wr(2'd3, 8'h03);
    settle();
    count(40, c);
    chk("R7 frac ratio", c, 16);

    // R8 pre-divider 3
    wr(2'd1, 8'd2);
    wr(2'd3, 8'h02);
    settle();
    chk("R8 pre applied", int'(act_pre), 2);
    count(60, c);
    chk("R8 pre ratio", c, 8);

    // R10 disabled input ignored
    clk_en = 1'b0;
    count(20, c);
    chk("R10 gated", c, 0);
    clk_en = 1'b1;
    count(30, c);
    chk("R10 resumes", c, 4);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule